// File: doc/BRIEF.md
# DMA External Request Detector

This block sits in front of a single DMA channel. It decides when the channel's transfer engine receives a transfer request. The request can come from one of two sources. The first is an asynchronous request pin from an external device. The second is a one-cycle request pulse from an on-chip peripheral, such as a transmit-empty or receive-full strobe. The device that raises the request need not be the source or the destination of the transfer that follows.

The pin is synchronized first. It is then qualified as a level or an edge, of either polarity. Once a request has been issued, the block stops watching its inputs until the engine returns the acknowledge strobe for that request. While the pin is level-qualified, a policy bit chooses between two options:

- one transfer for each request;
- one transfer beyond the number of requests, because the level seen in the acknowledge cycle itself counts as a new request.

Every request is suppressed unless both the channel enable and the controller enable are set, and none of the three error flags is raised.

Top module: `dma_ext_req_detect`

## Requirements
- R1: While `rst_n` is low, `req_o` is low. Reset also clears the pending state and the edge history.
- R2: With `det_mode_i` = 2'b00 (bit 1 = active-high polarity, bit 0 = edge qualification), a low synchronized pin is a request. The pin reaches the output three clock edges after it changes: two synchronizer stages, then the output register.
- R3: With `det_mode_i` = 2'b10, a high synchronized pin is a request.
- R4: With `det_mode_i` = 2'b11, only a low-to-high transition is a request. With 2'b01, only a high-to-low transition is a request. A level held after acknowledge produces no further request.
- R5: From an issued request until `ack_i` is sampled high, the block issues no new request. An edge or peripheral pulse that arrives during this window is discarded, not queued.
- R6: In level mode with `extra_xfer_i` = 0, the pin is looked at again only in the cycle after the acknowledge edge. A request that was withdrawn before then yields no further transfer.
- R7: In level mode with `extra_xfer_i` = 1, a pin still active in the acknowledge cycle issues a new request on the acknowledge edge itself. This gives one transfer more than requested.
- R8: A request is issued only when `ch_en_i` = 1, `ctl_en_i` = 1, `xfer_err_i` = 0, `addr_err_i` = 0 and `nmi_flag_i` = 0, all sampled on the edge that issues it.
- R9: With `src_periph_i` = 1, a high `periph_req_i` on a clock edge issues a request on that edge, and the pin is ignored.
- R10: Each request is a single-cycle pulse on `req_o`.
- R11: Changing `src_periph_i` while a request is pending has no effect until `ack_i`. A request from the newly selected source follows on the edge after the acknowledge edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req_i | input | 1 | Asynchronous request pin from an external device |
| det_mode_i | input | 2 | Bit 1: active-high polarity; bit 0: edge qualification |
| extra_xfer_i | input | 1 | Level-mode policy: 1 allows one extra transfer |
| src_periph_i | input | 1 | 1 selects the peripheral pulse, 0 selects the pin |
| periph_req_i | input | 1 | Synchronous request pulse from an on-chip peripheral |
| ch_en_i | input | 1 | Channel enable |
| ctl_en_i | input | 1 | Controller-wide enable |
| xfer_err_i | input | 1 | Transfer-end flag of the channel |
| addr_err_i | input | 1 | Address-error flag |
| nmi_flag_i | input | 1 | Non-maskable-interrupt flag |
| ack_i | input | 1 | Acknowledge strobe from the transfer engine |
| req_o | output | 1 | One-cycle transfer request |

## Verification
The checker assumes the engine only ever acknowledges a pending request, and never on the edge directly after the one that raised `req_o`. Under that assumption, a request pulse followed at once by another is a design fault and not a legal sequence. The stimulus follows this by raising `ack_i` for one cycle only, at least two cycles after each observed request. It also changes the pin only at falling clock edges. The enables and the detection mode are set up while the pin sits at its idle level, so that the synchronizer's fill after reset cannot be mistaken for a request.

// File: rtl/dma_ext_req_pkg.sv
// Package: shared types for the DMA external request detector.
// Assumes: the detection mode arrives as a 2-bit field, polarity in bit 1.
package dma_ext_req_pkg;

    // Decoded detection configuration; bit order matches det_mode_i.
    typedef struct packed {
        logic pol_high;   // 1: active-high / rising, 0: active-low / falling
        logic edge_sel;   // 1: edge qualified, 0: level qualified
    } det_cfg_t;

    // Minimum synchronizer depth the detector supports.
    localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/dreq_sync.sv
// Module: dreq_sync
// Brings the asynchronous request pin into the clock domain with a chain of
// STAGES flops. Assumes STAGES >= 2 and a synchronous active-low reset.
module dreq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages: pass the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/req_qualifier.sv
// Module: req_qualifier
// Turns the synchronized pin into a request condition according to the
// detection configuration: level or edge, either polarity. It keeps one bit
// of history, which advances every cycle, so that edges arriving while the
// block is masked are consumed and lost. Assumes a synchronous active-low reset.
module req_qualifier
    import dma_ext_req_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sample_i,
    input  det_cfg_t cfg_i,
    output logic     hit_o
);
    logic prev_q;
    logic level_hit;
    logic rise_hit;
    logic fall_hit;
    logic edge_hit;

    // Edge history: the previous synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sample_i;
    end

    // Qualification: choose level or edge with the configured polarity.
    always_comb begin
        level_hit = cfg_i.pol_high ? sample_i : ~sample_i;
        rise_hit  = sample_i & ~prev_q;
        fall_hit  = ~sample_i & prev_q;
        edge_hit  = cfg_i.pol_high ? rise_hit : fall_hit;
        hit_o     = cfg_i.edge_sel ? edge_hit : level_hit;
    end
endmodule

// File: rtl/req_tracker.sv
// Module: req_tracker
// Selects the request source and applies the enable gate. It issues
// single-cycle requests and keeps at most one request pending until the
// acknowledge arrives. In level mode with the extra-transfer policy, a hit
// during the acknowledge cycle is accepted at once.
// Assumes: ack_i only arrives for a pending request.
module req_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_hit_i,
    input  logic periph_hit_i,
    input  logic src_periph_i,
    input  logic level_mode_i,
    input  logic extra_xfer_i,
    input  logic enabled_i,
    input  logic ack_i,
    output logic req_o
);
    logic pending_q;
    logic req_q;
    logic src_hit;
    logic extra_window;
    logic can_accept;
    logic fire;

    // Acceptance: source select, masking window and enable gate.
    always_comb begin
        src_hit      = src_periph_i ? periph_hit_i : ext_hit_i;
        extra_window = ack_i & pending_q & extra_xfer_i & level_mode_i & ~src_periph_i;
        can_accept   = ~pending_q | extra_window;
        fire         = enabled_i & can_accept & src_hit;
    end

    // Pending flag: set by an issued request, cleared by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending_q <= 1'b0;
        else if (fire)  pending_q <= 1'b1;
        else if (ack_i) pending_q <= 1'b0;
    end

    // Output register: one-cycle request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= fire;
    end

    assign req_o = req_q;
endmodule

// File: rtl/dma_ext_req_detect.sv
// Module: dma_ext_req_detect (top)
// Front end of one DMA channel. It synchronizes and qualifies the external
// request pin, or takes the peripheral pulse, gates the result with the
// enable and error flags, and issues one-cycle transfer requests.
// Assumes: periph_req_i and all control inputs are synchronous to clk.
module dma_ext_req_detect
    import dma_ext_req_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_req_i,
    input  logic [1:0] det_mode_i,
    input  logic       extra_xfer_i,
    input  logic       src_periph_i,
    input  logic       periph_req_i,
    input  logic       ch_en_i,
    input  logic       ctl_en_i,
    input  logic       xfer_err_i,
    input  logic       addr_err_i,
    input  logic       nmi_flag_i,
    input  logic       ack_i,
    output logic       req_o
);
    det_cfg_t cfg;
    logic     pin_sync;
    logic     ext_hit;
    logic     enabled;

    // Decode the mode field and the enable gate.
    always_comb begin
        cfg     = det_cfg_t'(det_mode_i);
        enabled = ch_en_i & ctl_en_i & ~xfer_err_i & ~addr_err_i & ~nmi_flag_i;
    end

    dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_req_i),
        .sync_o  (pin_sync)
    );

    req_qualifier u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (pin_sync),
        .cfg_i    (cfg),
        .hit_o    (ext_hit)
    );

    req_tracker u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_hit_i    (ext_hit),
        .periph_hit_i (periph_req_i),
        .src_periph_i (src_periph_i),
        .level_mode_i (~cfg.edge_sel),
        .extra_xfer_i (extra_xfer_i),
        .enabled_i    (enabled),
        .ack_i        (ack_i),
        .req_o        (req_o)
    );
endmodule

// File: rtl/dma_ext_req_detect_chk.sv
// Module: dma_ext_req_detect_chk
// Port-level checker for dma_ext_req_detect, bound to every instance.
// Assumes: ack_i only follows a pending request, and not on the edge
// directly after the request pulse.
module dma_ext_req_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic req_o,
    input logic ack_i,
    input logic ch_en_i,
    input logic ctl_en_i,
    input logic xfer_err_i,
    input logic addr_err_i,
    input logic nmi_flag_i
);
    logic pend_q;

    // Independent model of the pending request, built from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (req_o) pend_q <= 1'b1;
        else if (ack_i) pend_q <= 1'b0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !req_o);

    // R10
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R8
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(ch_en_i & ctl_en_i & ~xfer_err_i & ~addr_err_i & ~nmi_flag_i));

    // R5
    single_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !pend_q);
endmodule

bind dma_ext_req_detect dma_ext_req_detect_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_o      (req_o),
    .ack_i      (ack_i),
    .ch_en_i    (ch_en_i),
    .ctl_en_i   (ctl_en_i),
    .xfer_err_i (xfer_err_i),
    .addr_err_i (addr_err_i),
    .nmi_flag_i (nmi_flag_i)
);

// File: tb/dma_ext_req_detect_bench.sv
// Directed bench for dma_ext_req_detect: one task per scenario.
module dma_ext_req_detect_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_req = 1'b0;
    logic [1:0] det_mode = 2'b10;
    logic       extra_xfer = 1'b0;
    logic       src_periph = 1'b0;
    logic       periph_req = 1'b0;
    logic       ch_en = 1'b0;
    logic       ctl_en = 1'b0;
    logic       xfer_err = 1'b0;
    logic       addr_err = 1'b0;
    logic       nmi_flag = 1'b0;
    logic       ack = 1'b0;
    logic       req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dma_ext_req_detect u_dma_ext_req_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_req_i    (ext_req),
        .det_mode_i   (det_mode),
        .extra_xfer_i (extra_xfer),
        .src_periph_i (src_periph),
        .periph_req_i (periph_req),
        .ch_en_i      (ch_en),
        .ctl_en_i     (ctl_en),
        .xfer_err_i   (xfer_err),
        .addr_err_i   (addr_err),
        .nmi_flag_i   (nmi_flag),
        .ack_i        (ack),
        .req_o        (req)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count request pulses over the next n falling edges.
    task automatic count_reqs(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req) c++;
        end
    endtask

    task automatic do_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    // Reset with the pin idle for the chosen mode, then enable the channel.
    task automatic setup(input logic [1:0] mode, input logic xtra);
        rst_n = 1'b0; ch_en = 1'b0; ctl_en = 1'b0; src_periph = 1'b0;
        det_mode = mode; extra_xfer = xtra;
        ext_req = ~mode[1];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        ch_en = 1'b1; ctl_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        int c;
        rst_n = 1'b0; ch_en = 1'b1; ctl_en = 1'b1; det_mode = 2'b10; ext_req = 1'b1;
        count_reqs(5, c);
        check("R1 reset holds req low", c, 0);
        ch_en = 1'b0; ctl_en = 1'b0; ext_req = 1'b0;
    endtask

    task automatic t_level(input logic pol);
        int c;
        string tag;
        tag = pol ? "R3 high level" : "R2 low level";
        setup({pol, 1'b0}, 1'b0);
        count_reqs(4, c);
        check({tag, " idle"}, c, 0);
        ext_req = pol;
        @(negedge clk); @(negedge clk);
        check({tag, " not before sync"}, int'(req), 0);
        @(negedge clk);
        check({tag, " request on third edge"}, int'(req), 1);
        count_reqs(4, c);
        check("R10 single pulse while held", c, 0);
        ext_req = ~pol;
        repeat (3) @(negedge clk);
        do_ack();
        count_reqs(4, c);
        check({tag, " none after withdraw"}, c, 0);
    endtask

    task automatic t_edge(input logic pol);
        int c;
        setup({pol, 1'b1}, 1'b0);
        ext_req = pol;
        count_reqs(6, c);
        check("R4 edge gives one request", c, 1);
        do_ack();
        count_reqs(6, c);
        check("R4 held level after ack gives none", c, 0);
        ext_req = ~pol;
        count_reqs(3, c);
        check("R4 opposite edge ignored", c, 0);
        ext_req = pol;
        count_reqs(6, c);
        check("R4 second edge gives request", c, 1);
        do_ack();
    endtask

    task automatic t_mask();
        int c;
        setup(2'b11, 1'b0);
        ext_req = 1'b1;
        count_reqs(6, c);
        check("R5 first edge", c, 1);
        ext_req = 1'b0;
        repeat (3) @(negedge clk);
        ext_req = 1'b1;
        count_reqs(6, c);
        check("R5 edge while pending ignored", c, 0);
        do_ack();
        count_reqs(6, c);
        check("R5 masked edge not queued", c, 0);
        ext_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_overrun(input logic xtra);
        int c;
        int first;
        string tag;
        tag = xtra ? "R7 extra transfer" : "R6 exact transfers";
        setup(2'b10, xtra);
        ext_req = 1'b1;
        count_reqs(5, first);
        ext_req = 1'b0;
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        c = first + int'(req);
        begin
            int more;
            count_reqs(6, more);
            c += more;
        end
        check(tag, c, xtra ? 2 : 1);
        if (xtra) do_ack();
    endtask

    task automatic t_gate();
        int c;
        for (int i = 0; i < 5; i++) begin
            setup(2'b10, 1'b0);
            case (i)
                0: ch_en = 1'b0;
                1: ctl_en = 1'b0;
                2: xfer_err = 1'b1;
                3: addr_err = 1'b1;
                default: nmi_flag = 1'b1;
            endcase
            ext_req = 1'b1;
            count_reqs(6, c);
            check($sformatf("R8 gate %0d blocks", i), c, 0);
            ch_en = 1'b1; ctl_en = 1'b1; xfer_err = 1'b0; addr_err = 1'b0; nmi_flag = 1'b0;
            count_reqs(4, c);
            check($sformatf("R8 gate %0d released", i), c, 1);
            ext_req = 1'b0;
            repeat (3) @(negedge clk);
            do_ack();
        end
    endtask

    task automatic t_periph();
        int c;
        int more;
        setup(2'b10, 1'b0);
        src_periph = 1'b1;
        ext_req = 1'b1;
        count_reqs(6, c);
        check("R9 pin ignored in peripheral mode", c, 0);
        periph_req = 1'b1;
        @(negedge clk);
        c = int'(req);
        periph_req = 1'b0;
        check("R9 pulse gives request on its edge", c, 1);
        count_reqs(4, more);
        check("R10 peripheral request single pulse", more, 0);
        src_periph = 1'b0;
        count_reqs(6, c);
        check("R11 source change waits for ack", c, 0);
        do_ack();
        count_reqs(4, c);
        check("R11 new source after ack", c, 1);
        ext_req = 1'b0;
        repeat (3) @(negedge clk);
        do_ack();
    endtask

    initial begin
        t_reset();
        t_level(1'b0);
        t_level(1'b1);
        t_edge(1'b1);
        t_edge(1'b0);
        t_mask();
        t_overrun(1'b0);
        t_overrun(1'b1);
        t_gate();
        t_periph();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule